// File: doc/BRIEF.md
# Early-Terminating Integer Divider

This block divides one 32-bit integer by another and returns both quotient and remainder. An input selects two's-complement or unsigned operation. A caller presents the operands with a one-cycle `start` pulse while the unit is idle. The unit then holds `busy` high while it works, and raises `done` for a single cycle when the results are valid. The results stay on the outputs until the next division completes.

The core is a restoring divider that produces two quotient bits per clock. It works on magnitudes. Before iterating it counts the leading zeros of the dividend magnitude. It then starts at the first bit pair that can give a nonzero quotient bit, so short dividends finish early. A floor of six iterations keeps the shortest operation at six clocks, and a full-width dividend needs sixteen. Once the magnitudes are divided, the signs are applied: the quotient is negated when exactly one operand is negative, and the remainder carries the sign of the dividend. Division by zero and the one signed overflow case, most-negative divided by minus one, each return fixed results.

Top module: `early_div`

## Requirements
- R1: With `is_signed` low, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, both read as unsigned values, for every nonzero divisor.
- R2: With `is_signed` high and a nonzero divisor, the operands are read as two's complement. The quotient is rounded toward zero, so its sign is the XOR of the operand signs. The remainder has the sign of the dividend and a magnitude smaller than that of the divisor.
- R3: For a nonzero divisor, let n be the bit length of the dividend magnitude (0 for a zero dividend). The clock edge that accepts `start` counts as edge 0. `done` goes high after edge max(6, ceil(n/2)), so every operation takes between 6 and 16 clocks.
- R4: With a zero divisor, in either mode, `done` goes high after edge 6. `quotient` is all ones and `remainder` equals the original dividend.
- R5: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives a quotient of 0x80000000 and a remainder of 0.
- R6: `busy` is high from the edge after the accepting edge until `done` rises. `done` is high for exactly one cycle, and `busy` is low whenever `done` is high.
- R7: A `start` pulse seen while `busy` is high is ignored. It does not change the result or the latency of the division in flight, and no extra completion follows it.
- R8: While `rst_n` is low, `busy`, `done`, `quotient` and `remainder` are all zero.
- R9: `quotient` and `remainder` change only on the edge that raises `done`, and they hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; taken only while idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled on the accepting edge |
| divisor | input | 32 | Divisor, sampled on the accepting edge |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion strobe |
| quotient | output | 32 | Result quotient, held until the next completion |
| remainder | output | 32 | Result remainder, held until the next completion |

## Verification
The assertions make three assumptions about the inputs:
- `start`, `is_signed` and the operands are defined, non-X levels on every edge, and they matter only on the edge that accepts a request.
- Reset is applied before the first request.
- When a request is taken, the partial remainder starts below the divisor, which the bound check in the iteration stage depends on.

The stimulus meets these assumptions by changing inputs only on falling clock edges and by holding reset across the first cycles. Apart from one deliberate test, it issues single-cycle `start` pulses only when the unit is idle. That test holds `start` high in the middle of a division, with different operands, to exercise R7.

// File: rtl/early_div_pkg.sv
package early_div_pkg;
  // quotient bits retired per clock (radix 4)
  localparam int unsigned DIV_STEP_BITS = 2;

  typedef struct packed {
    logic q_neg;    // negate magnitude quotient at the end
    logic r_neg;    // negate magnitude remainder at the end
    logic by_zero;  // divisor was zero
  } div_flags_t;
endpackage

// File: rtl/early_div_lzc.sv
module early_div_lzc #(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [LW-1:0] zeros
);
  // ascending scan: the highest set bit written last wins
  always_comb begin
    zeros = LW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = LW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/early_div_step.sv
module early_div_step #(
  parameter int unsigned W  = 32,
  parameter int unsigned SB = 2
) (
  input  logic [W-1:0]  rem_in,
  input  logic [SB-1:0] bits_in,
  input  logic [W-1:0]  dsr,
  output logic [W-1:0]  rem_out,
  output logic [SB-1:0] q_out
);
  logic [W-1:0] chain [0:SB];

  assign chain[0] = rem_in;

  for (genvar g = 0; g < SB; g++) begin : g_sub
    logic [W:0] trial;
    logic [W:0] diff;
    logic       ge;
    assign trial           = {chain[g], bits_in[SB-1-g]};
    assign diff            = trial - {1'b0, dsr};
    assign ge              = (trial >= {1'b0, dsr});
    assign chain[g+1]      = ge ? diff[W-1:0] : trial[W-1:0];
    assign q_out[SB-1-g]   = ge;
  end

  assign rem_out = chain[SB];

  // R1: a partial remainder below the divisor stays below it
  always_comb begin
    if ((dsr != '0) && (rem_in < dsr)) begin
      rem_bound_chk: assert (rem_out < dsr);
    end
  end
endmodule

// File: rtl/early_div.sv
module early_div
  import early_div_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter int unsigned MIN_ITERS = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int unsigned SB    = DIV_STEP_BITS;
  localparam int unsigned ITERS = W / SB;
  localparam int unsigned CW    = $clog2(ITERS + 2);
  localparam int unsigned LW    = $clog2(W + 1);

  // ---------------- registers ----------------
  logic           busy_q, done_q;
  logic [CW-1:0]  iter_q, lat_q;
  logic [W-1:0]   dvd_q, rem_q, quo_q, dsr_q, orig_q;
  logic [W-1:0]   quot_q, rmd_q;
  div_flags_t     flg_q;

  // ---------------- next state ----------------
  logic           busy_d, done_d;
  logic [CW-1:0]  iter_d;
  logic [W-1:0]   dvd_d, rem_d, quo_d, dsr_d, orig_d;
  logic [W-1:0]   quot_d, rmd_d;
  div_flags_t     flg_d;

  // ---------------- operand preparation ----------------
  logic           accept, fin, work_en;
  logic           a_neg, b_neg, b_zero;
  logic [W-1:0]   a_mag, b_mag, dvd_start;
  logic [LW-1:0]  a_lz;
  logic [LW:0]    sig_bits, need, shamt;
  logic [W-1:0]   rem_nx, q_full, q_res, r_res;
  logic [SB-1:0]  qb_nx;

  assign accept  = start & ~busy_q;
  assign fin     = busy_q & (iter_q == CW'(1));
  assign work_en = accept | busy_q;

  always_comb begin
    a_neg  = is_signed & dividend[W-1];
    b_neg  = is_signed & divisor[W-1];
    a_mag  = a_neg ? ({W{1'b0}} - dividend) : dividend;
    b_mag  = b_neg ? ({W{1'b0}} - divisor) : divisor;
    b_zero = (divisor == '0);
  end

  early_div_lzc #(.W(W), .LW(LW)) u_lzc (
    .vec   (a_mag),
    .zeros (a_lz)
  );

  // pick the first bit pair that can yield a quotient bit, floor at MIN_ITERS
  always_comb begin
    sig_bits = (LW+1)'(W) - {1'b0, a_lz};
    need     = (sig_bits + (LW+1)'(1)) >> 1;
    if (b_zero || (need < (LW+1)'(MIN_ITERS))) need = (LW+1)'(MIN_ITERS);
    shamt     = (LW+1)'(W) - (need << 1);
    dvd_start = a_mag << shamt;
  end

  // ---------------- iteration datapath ----------------
  early_div_step #(.W(W), .SB(SB)) u_step (
    .rem_in  (rem_q),
    .bits_in (dvd_q[W-1 -: SB]),
    .dsr     (dsr_q),
    .rem_out (rem_nx),
    .q_out   (qb_nx)
  );

  always_comb begin
    q_full = {quo_q[W-SB-1:0], qb_nx};
    q_res  = flg_q.by_zero ? {W{1'b1}}
           : (flg_q.q_neg ? ({W{1'b0}} - q_full) : q_full);
    r_res  = flg_q.by_zero ? orig_q
           : (flg_q.r_neg ? ({W{1'b0}} - rem_nx) : rem_nx);
  end

  // ---------------- control ----------------
  always_comb begin
    busy_d = busy_q;
    iter_d = iter_q;
    dvd_d  = dvd_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dsr_d  = dsr_q;
    orig_d = orig_q;
    flg_d  = flg_q;
    done_d = 1'b0;
    quot_d = quot_q;
    rmd_d  = rmd_q;
    if (accept) begin
      busy_d        = 1'b1;
      iter_d        = CW'(need);
      dvd_d         = dvd_start;
      rem_d         = '0;
      quo_d         = '0;
      dsr_d         = b_mag;
      orig_d        = dividend;
      flg_d.q_neg   = a_neg ^ b_neg;
      flg_d.r_neg   = a_neg;
      flg_d.by_zero = b_zero;
    end else if (busy_q) begin
      rem_d  = rem_nx;
      quo_d  = q_full;
      dvd_d  = dvd_q << SB;
      iter_d = iter_q - CW'(1);
      if (fin) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        quot_d = q_res;
        rmd_d  = r_res;
      end
    end
  end

  // ---------------- state registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iter_q <= '0;
      dvd_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      orig_q <= '0;
      flg_q  <= '0;
    end else begin
      done_q <= done_d;
      if (work_en) begin
        busy_q <= busy_d;
        iter_q <= iter_d;
        dvd_q  <= dvd_d;
        rem_q  <= rem_d;
        quo_q  <= quo_d;
        dsr_q  <= dsr_d;
        orig_q <= orig_d;
        flg_q  <= flg_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
      rmd_q  <= '0;
    end else if (fin) begin
      quot_q <= quot_d;
      rmd_q  <= rmd_d;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign quotient  = quot_q;
  assign remainder = rmd_q;

  // ---------------- checks ----------------
  // elapsed-clock counter kept for the latency window check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (accept) lat_q <= CW'(1);
    else if (busy_q) lat_q <= lat_q + CW'(1);
  end

  // R3
  lat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ((lat_q >= CW'(MIN_ITERS)) && (lat_q <= CW'(ITERS))));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));

  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> ($stable(dsr_q) && $stable(flg_q)));

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(quot_q) && $stable(rmd_q)) |-> done_q);
endmodule

// File: tb/early_div_tb.sv
`timescale 1ns/1ps
module early_div_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        is_signed;
  logic [31:0] dividend;
  logic [31:0] divisor;
  logic        busy;
  logic        done;
  logic [31:0] quotient;
  logic [31:0] remainder;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] last_q, last_r;

  always #2.5 clk = ~clk;

  early_div u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic int exp_lat(bit s, logic [31:0] a, logic [31:0] b);
    logic [31:0] mag;
    int n, k;
    if (b == 0) return 6;
    mag = (s && a[31]) ? (32'd0 - a) : a;
    n = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) n = i + 1;
    k = (n + 1) / 2;
    return (k < 6) ? 6 : k;
  endfunction

  function automatic logic [31:0] exp_q(bit s, logic [31:0] a, logic [31:0] b);
    logic signed [31:0] sa, sb;
    if (b == 0) return 32'hFFFF_FFFF;
    if (!s) return a / b;
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
    sa = a; sb = b;
    return sa / sb;
  endfunction

  function automatic logic [31:0] exp_r(bit s, logic [31:0] a, logic [31:0] b);
    logic signed [31:0] sa, sb;
    if (b == 0) return a;
    if (!s) return a % b;
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h0;
    sa = a; sb = b;
    return sa % sb;
  endfunction

  task automatic run_op(input bit s, input logic [31:0] a, input logic [31:0] b);
    int cyc;
    bit busy_ok;
    string rq, rl;
    logic [31:0] eq, er;
    if (b == 0) rq = "R4";
    else if (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) rq = "R5";
    else if (s) rq = "R2";
    else rq = "R1";
    rl = (b == 0) ? "R4" : "R3";
    eq = exp_q(s, a, b);
    er = exp_r(s, a, b);
    @(negedge clk);
    is_signed = s; dividend = a; divisor = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    busy_ok = busy;
    cyc = 0;
    while (cyc < 40) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) break;
      if (!busy) busy_ok = 1'b0;
    end
    chk(cyc == exp_lat(s, a, b), rl, "latency", cyc, exp_lat(s, a, b));
    chk(quotient == eq, rq, "quotient", quotient, eq);
    chk(remainder == er, rq, "remainder", remainder, er);
    chk(busy_ok && !busy, "R6", "busy window", {31'd0, busy_ok}, 32'd1);
    last_q = eq;
    last_r = er;
    @(negedge clk);
    chk(!done, "R6", "done width", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!busy && !done, "R8", "busy/done in reset", {30'd0, busy, done}, 32'd0);
    chk(quotient == 0, "R8", "quotient in reset", quotient, 32'd0);
    chk(remainder == 0, "R8", "remainder in reset", remainder, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // corners: R4 zero divisor, R5 overflow, R2 signs
    run_op(1'b0, 32'd12345, 32'd0);
    run_op(1'b1, 32'hFFFF_FF85, 32'd0);
    run_op(1'b0, 32'd0, 32'd0);
    run_op(1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op(1'b1, 32'h8000_0000, 32'd1);
    run_op(1'b1, 32'hFFFF_FFFF, 32'h8000_0000);
    run_op(1'b1, 32'd7, 32'hFFFF_FFFE);
    run_op(1'b1, 32'hFFFF_FFF9, 32'd2);
    run_op(1'b1, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
    run_op(1'b0, 32'hFFFF_FFFF, 32'd1);
    run_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(1'b0, 32'd5, 32'd9);

    // R9 outputs hold between completions
    repeat (6) @(negedge clk);
    chk(quotient == last_q, "R9", "quotient hold", quotient, last_q);
    chk(remainder == last_r, "R9", "remainder hold", remainder, last_r);

    // sweep of dividend bit length (R3) in both modes
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n <= 32; n++) begin
        for (int d = 0; d < 6; d++) begin
          logic [31:0] a, b, mask;
          mask = (n == 0) ? 32'd0 : (32'hFFFF_FFFF >> (32 - n));
          a = (n == 0) ? 32'd0 : ((32'd1 << (n - 1)) | (rnd() & mask));
          case (d)
            0: b = 32'd1;
            1: b = 32'd3;
            2: b = 32'd7;
            3: b = 32'h0000_FFFF;
            4: b = 32'hFFFF_FFFD;
            default: b = (rnd() >> 20) | 32'd1;
          endcase
          run_op(s[0], a, b);
        end
      end
    end

    // pseudo-random pairs with varied divisor lengths
    for (int t = 0; t < 400; t++) begin
      logic [31:0] a, b;
      a = rnd() >> (rnd() % 32);
      b = rnd() >> (rnd() % 32);
      run_op(t[0], a, b);
    end

    // R7 start while busy is ignored
    begin
      int cyc;
      bit extra;
      @(negedge clk);
      is_signed = 1'b0; dividend = 32'd1000000; divisor = 32'd7; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (cyc < 40) begin
        @(posedge clk);
        cyc++;
        @(negedge clk);
        if (cyc == 2) begin
          is_signed = 1'b1; dividend = 32'd5; divisor = 32'd1; start = 1'b1;
        end
        if (cyc == 4) start = 1'b0;
        if (done) break;
      end
      chk(cyc == exp_lat(1'b0, 32'd1000000, 32'd7), "R7", "latency under restart",
          cyc, exp_lat(1'b0, 32'd1000000, 32'd7));
      chk(quotient == 32'd142857, "R7", "quotient under restart", quotient, 32'd142857);
      chk(remainder == 32'd1, "R7", "remainder under restart", remainder, 32'd1);
      extra = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (done || busy) extra = 1'b1;
      end
      chk(!extra, "R7", "no extra completion", {31'd0, extra}, 32'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule